// File: doc/BRIEF.md
# Cell Transmit Rate Pacer

This block decides, cycle by cycle, when an ATM cell transmitter may send a cell. It works in one of two pacing modes. In the FIFO-driven mode the downstream PHY sets the pace. Whenever the PHY transmit FIFO has room, the block either grants a pending data cell or asks for a filler (idle or unassigned) cell, so the FIFO never runs dry.

In the timer-driven mode the line rate comes from a bank of reloadable down-counters. These count on an external baud-rate tick rather than on the system clock. Each counter has its own initial value and enable. When a counter expires it raises a transmit request for its rate, and that request stays posted until the transmitter acknowledges it. Filler cells are never requested in this mode.

The mode input is only sampled at a cell boundary. Changing the mode clears every posted request and reloads every counter.

Top module: `cell_pacer`

## Requirements
- R1: In FIFO-driven mode (`mode_int` = 0), when `fifo_full` is low and `data_pend` is high, `data_grant` is high in that same cycle.
- R2: In FIFO-driven mode, when `fifo_full` is low and `data_pend` is low, `idle_req` is high for that cycle. Each such cycle is one filler-cell slot.
- R3: While `fifo_full` is high, neither `data_grant` nor `idle_req` is asserted.
- R4: In timer-driven mode (`mode_int` = 1), `idle_req` and `data_grant` stay low whatever `fifo_full` and `data_pend` do.
- R5: A timer k that is enabled and has a nonzero initial value N moves only on cycles where `tick` is high. It posts a request on every (N+1)-th tick and reloads N on that same tick. The first expiry comes N+1 ticks after the timer becomes live.
- R6: A timer whose enable bit is low, or whose initial value is zero, never posts a request.
- R7: A posted request stays posted until `tx_ack` is high while `tx_req` is high. That acknowledge retires exactly the request shown on `tx_rate`. Expiries of a timer that still has a request posted merge into that one request.
- R8: When several requests are posted, `tx_rate` shows the lowest-numbered timer.
- R9: A new value on `mode_sel` is taken into `mode_int` only at a cell boundary. In FIFO-driven mode every cycle is a boundary. In timer-driven mode a boundary is a cycle with `tx_req` low, or with `tx_ack` high.
- R10: A mode change clears all posted requests and reloads all timers with their initial values.
- R11: After reset the block is in FIFO-driven mode with no requests posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Requested mode: 0 FIFO-driven, 1 timer-driven |
| tick | input | 1 | Baud-rate tick pulse that advances the timers |
| tmr_en | input | NTMR | Per-timer enable |
| tmr_init | input | NTMR*TW | Per-timer initial values; timer k uses bits [k*TW +: TW] |
| fifo_full | input | 1 | PHY transmit FIFO has no room |
| data_pend | input | 1 | A data cell is ready to send |
| tx_ack | input | 1 | Transmitter accepts the request shown on tx_rate |
| mode_int | output | 1 | Mode currently in effect |
| data_grant | output | 1 | Send a data cell in this slot |
| idle_req | output | 1 | Send a filler cell in this slot |
| tx_req | output | 1 | At least one timer request is posted |
| tx_rate | output | IW | Index of the lowest posted timer request |

## Verification
The hardest situation to reach from the ports is a mode change requested while timer requests are posted and unacknowledged. It must be held off until a boundary arrives, and it must then discard every posted request. The stimulus reaches it by running all timers with a tick on every cycle and withholding `tx_ack` until several requests have piled up. It then flips `mode_sel` and keeps acknowledges away for several cycles before releasing a single one. A behavioural model with per-timer integer counters follows the block on every clock, under random ticks, acknowledges and FIFO states. This includes disabled and zero-valued timers and merged expiries.

// File: rtl/cell_pacer.sv
module cell_pacer #(
  parameter int NTMR = 4,
  parameter int TW   = 16,
  localparam int IW  = (NTMR > 1) ? $clog2(NTMR) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_sel,
  input  logic                 tick,
  input  logic [NTMR-1:0]      tmr_en,
  input  logic [NTMR*TW-1:0]   tmr_init,
  input  logic                 fifo_full,
  input  logic                 data_pend,
  input  logic                 tx_ack,
  output logic                 mode_int,
  output logic                 data_grant,
  output logic                 idle_req,
  output logic                 tx_req,
  output logic [IW-1:0]        tx_rate
);

  logic            mode_q;
  logic [NTMR-1:0] pend, expire, ack_mask;
  logic [TW-1:0]   cnt [NTMR];

  assign mode_int   = mode_q;
  assign tx_req     = mode_q && (|pend);
  assign data_grant = !mode_q && !fifo_full && data_pend;
  assign idle_req   = !mode_q && !fifo_full && !data_pend;

  wire boundary = !mode_q || !tx_req || tx_ack;
  wire switch_m = boundary && (mode_sel != mode_q);

  always_comb begin
    tx_rate = '0;
    for (int i = NTMR - 1; i >= 0; i--)
      if (pend[i]) tx_rate = IW'(i);
  end

  assign ack_mask = (tx_ack && mode_q) ? (pend & (~pend + 1'b1)) : '0;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    wire [TW-1:0] ival = tmr_init[g*TW +: TW];
    wire          live = tmr_en[g] && (ival != '0);
    assign expire[g] = mode_q && live && tick && (cnt[g] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n)                         cnt[g] <= '0;
      else if (!mode_q || switch_m || !live) cnt[g] <= ival;
      else if (tick)                      cnt[g] <= (cnt[g] == '0) ? ival : cnt[g] - 1'b1;
    end

    p_dead_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !$past(pend[g])) |-> !expire[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pend <= '0;
    else if (switch_m || !mode_q) pend <= '0;
    else                        pend <= (pend & ~ack_mask) | expire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mode_q <= 1'b0;
    else if (switch_m) mode_q <= mode_sel;
  end

  p_one_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_grant, idle_req, tx_req}));

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_ack) |=> tx_req);

  p_low_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_ack) |=> (tx_rate <= $past(tx_rate)));

  p_mode_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && tx_req && !tx_ack) |=> mode_q);

  p_mode_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (pend == '0));

  p_tick_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != '0) |-> $past(tick));

endmodule

// File: tb/cell_pacer_bench.sv
module cell_pacer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic mode_sel = 0, tick = 0, fifo_full = 1, data_pend = 0, tx_ack = 0;
  logic [3:0]  tmr_en = 0;
  logic [15:0] iv [4];
  logic [63:0] tmr_init;
  logic mode_int, data_grant, idle_req, tx_req;
  logic [1:0] tx_rate;

  assign tmr_init = {iv[3], iv[2], iv[1], iv[0]};

  cell_pacer u_cell_pacer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tick(tick),
    .tmr_en(tmr_en), .tmr_init(tmr_init), .fifo_full(fifo_full),
    .data_pend(data_pend), .tx_ack(tx_ack), .mode_int(mode_int),
    .data_grant(data_grant), .idle_req(idle_req), .tx_req(tx_req),
    .tx_rate(tx_rate));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit m_mode, m_bnd, m_done;
  bit [3:0] m_pend;
  int m_cnt [4];
  bit seen_dead = 0;
  bit watch_dead = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pend = 0;
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    end else begin
      m_bnd = !m_mode || m_pend == 0 || tx_ack;
      if (m_bnd && mode_sel != m_mode) begin
        m_mode = mode_sel; m_pend = 0;
        for (int i = 0; i < 4; i++) m_cnt[i] = int'(iv[i]);
      end else if (!m_mode) begin
        for (int i = 0; i < 4; i++) m_cnt[i] = int'(iv[i]);
      end else begin
        if (tx_ack && m_pend != 0) begin
          m_done = 0;
          for (int i = 0; i < 4; i++)
            if (m_pend[i] && !m_done) begin m_pend[i] = 0; m_done = 1; end
        end
        for (int i = 0; i < 4; i++) begin
          if (!tmr_en[i] || iv[i] == 0) m_cnt[i] = int'(iv[i]);
          else if (tick) begin
            if (m_cnt[i] == 0) begin m_pend[i] = 1; m_cnt[i] = int'(iv[i]); end
            else m_cnt[i] = m_cnt[i] - 1;
          end
        end
      end
    end
  end

  function automatic int low_idx(input bit [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return i;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 R3 R4 data_grant", int'(data_grant), int'(!m_mode && !fifo_full && data_pend));
      check("R2 R3 R4 idle_req", int'(idle_req), int'(!m_mode && !fifo_full && !data_pend));
      check("R5 R6 R7 R10 tx_req", int'(tx_req), int'(m_mode && m_pend != 0));
      check("R9 mode_int", int'(mode_int), int'(m_mode));
      if (m_pend != 0) check("R8 tx_rate", int'(tx_rate), low_idx(m_pend));
      if (watch_dead && tx_req && tx_rate >= 2) seen_dead = 1;
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    iv[0] = 3; iv[1] = 5; iv[2] = 0; iv[3] = 2;
    step(3);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset mode", int'(mode_int), 0);
    check("R11 reset tx_req", int'(tx_req), 0);
    step(1);

    for (int k = 0; k < 60; k++) begin
      fifo_full = ($urandom % 3) == 0;
      data_pend = $urandom % 2;
      step(1);
    end
    fifo_full = 1; data_pend = 1;
    @(negedge clk);
    check("R3 full blocks grant", int'(data_grant), 0);
    step(1);

    tmr_en = 4'b0111; mode_sel = 1; watch_dead = 1;
    for (int k = 0; k < 500; k++) begin
      tick = $urandom % 2;
      tx_ack = ($urandom % 10) < 3;
      fifo_full = $urandom % 2;
      data_pend = $urandom % 2;
      step(1);
    end
    watch_dead = 0;
    check("R6 dead timers silent", int'(seen_dead), 0);

    tmr_en = 4'b1111; iv[2] = 4; tick = 1; tx_ack = 0;
    step(30);
    mode_sel = 0;
    step(8);
    @(negedge clk);
    check("R9 switch held off", int'(mode_int), 1);
    @(posedge clk); #1 tx_ack = 1;
    @(posedge clk); #1 tx_ack = 0;
    @(negedge clk);
    check("R10 switched out", int'(mode_int), 0);
    check("R10 requests cleared", int'(tx_req), 0);
    mode_sel = 1;
    step(1);
    @(negedge clk);
    check("R10 re-entered clean", int'(tx_req), 0);

    for (int k = 0; k < 400; k++) begin
      tick = ($urandom % 4) != 0;
      tx_ack = $urandom % 2;
      if (k % 97 == 50) mode_sel = ~mode_sel;
      if (k % 131 == 70) iv[1] = 16'($urandom % 6);
      step(1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule